// File: doc/BRIEF.md
# NAND Page Reed-Solomon Parity Engine

This block computes and checks Reed-Solomon parity for one 512-byte NAND page. It works on 10-bit symbols in GF(2^10), defined by x^10 + x^3 + 1, and produces six parity symbols. Page bytes arrive one per clock on a valid/ready stream. Before a byte reaches the division circuit, its eight bits are inverted and it is extended with two zero bits. As a result, an erased page of all 0xFF gives a zero remainder, and the inverted code bank then reads as all 0xFF.

Software uses a small register port to control the block. To write a page, it writes clear, generate and feed-enable, streams the 512 bytes, and reads the eight inverted code bytes to store them. To read a page back, it writes clear and feed-enable, streams the 512 bytes, and then streams the six stored 10-bit parity symbols in the form they were stored (inverted), highest-order first. The check register then reports whether the remainder is nonzero. When it is, the plain bank holds the remainder for software to use in error correction.

Back-pressure rules for the stream: a symbol is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low in three cases: feed is disabled, the page is complete (512 symbols in generate mode, 518 in check mode), or a control-register write is happening in that cycle. The source must hold `in_data` with `in_valid` until the symbol is taken.

Top module: `nand_rs_parity`

## Requirements
- R1: After reset:
  - the control and check registers read 0;
  - `in_ready` is low;
  - the parity state is zero, so every inverted code byte reads 0xFF, plain bytes 0..6 read 0x00 and plain byte 7 reads 0x0F.
- R2: `in_ready` is high only while feed-enable (control bit 5) is set and fewer than 512 symbols (generate mode) or 518 symbols (check mode) have been taken since the last clear. A symbol presented while `in_ready` is low changes nothing.
- R3: In generate mode the state holds the remainder of d(x)·x^6 divided by g(x) = (x+α^0)(x+α^1)…(x+α^5), with α = 2. Here d(x) is formed from the inverted page bytes, with the first byte as the highest-order coefficient.
- R4: A page of 512 bytes of 0xFF yields inverted code bytes that are all 0xFF.
- R5: The inverted bank (register words 16..23) forms a 64-bit little-endian word:
  - bits 9:0 hold the inverted parity coefficient of x^5;
  - each next 10-bit field holds the next lower coefficient, down to x^0 at bits 59:50;
  - bits 63:60 always read 1.
- R6: Plain bank word 8+k returns byte k of the same 64-bit word with the parity not inverted, still with bits 63:60 forced to 1, and with the eight bits of the byte mirrored (bit 7 ↔ bit 0).
- R7: In check mode, 512 data bytes are followed by 6 parity symbols. Each parity symbol is 10 bits and is fed in inverted form, x^5 coefficient first.
  - On the clock edge that takes the last parity symbol, check-register bit 7 becomes 1 if the remainder is nonzero and 0 if it is zero.
  - The check register does not change in generate mode.
- R8: Writing control bit 7 clears the parity state, the symbol count and the error flag on that edge, and loads bits 6 and 5 in the same write. Bit 7 reads back as 0.
- R9: Writing a control value with bit 5 clear stops the feed and holds the parity state and flag unchanged, whatever the stream does.
- R10: Register word map, read on `reg_rdata[7:0]`, with bits 15:8 reading 0:
  - 0: control (bits 7, 6, 5);
  - 1: check;
  - 8..15: plain bank;
  - 16..23: inverted bank;
  - every other word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Stream symbol valid |
| in_ready | output | 1 | Block can take a symbol this cycle |
| in_data | input | 10 | Data byte in bits 7:0, or a full 10-bit stored parity symbol |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |

## Verification
The assertions take three things for granted:
- `rst_n` is low before the first edge;
- `reg_addr` and `reg_we` carry defined values at every rising edge;
- mode bits change only together with a clear, so the symbol count never passes the check-mode page length.

The bench keeps within these rules by driving every input on the falling edge and by issuing every mode change with bit 7 set. It holds `in_valid` low during control writes, except where a stopped or full feed is the behaviour under test.

// File: rtl/rsp_pkg.sv
`timescale 1ns/1ps
package rsp_pkg;
  localparam int SYM_W = 10;
  localparam int NPAR  = 6;
  // low terms of x^10 + x^3 + 1
  localparam logic [SYM_W-1:0] FIELD_LOW = 10'h009;

  localparam logic [4:0] ADDR_CTRL = 5'd0;
  localparam logic [4:0] ADDR_CHK  = 5'd1;

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [NPAR:0]    gpoly_t;
  typedef sym_t [NPAR-1:0]  rem_t;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ({sh[SYM_W-2:0], 1'b0} ^ FIELD_LOW) : {sh[SYM_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  // product of (x + alpha^r) for r = 0 .. NPAR-1
  function automatic gpoly_t gen_poly();
    gpoly_t g;
    sym_t   root;
    g    = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int r = 0; r < NPAR; r++) begin
      for (int k = NPAR; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    return g;
  endfunction
endpackage

// File: rtl/rsp_lfsr.sv
`timescale 1ns/1ps
module rsp_lfsr
  import rsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  sym_t sym,
  output rem_t rem,
  output rem_t rem_nxt
);
  localparam gpoly_t GEN = gen_poly();

  sym_t fb;
  assign fb = sym ^ rem[NPAR-1];

  for (genvar k = 0; k < NPAR; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign rem_nxt[k] = gf_mul(fb, GEN[k]);
    end else begin : g_rest
      assign rem_nxt[k] = rem[k-1] ^ gf_mul(fb, GEN[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem <= '0;
    else if (clr)  rem <= '0;
    else if (step) rem <= rem_nxt;
  end

  // R9
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(rem));
endmodule

// File: rtl/rsp_ctrl.sv
`timescale 1ns/1ps
module rsp_ctrl
  import rsp_pkg::*;
#(
  parameter int PAGE_BYTES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_clr,
  input  logic wr_gen,
  input  logic wr_feed,
  input  logic in_valid,
  input  logic rem_nz,
  output logic in_ready,
  output logic step,
  output logic clr,
  output logic parity_phase,
  output logic gen_mode,
  output logic feed_en,
  output logic err
);
  localparam int CW = $clog2(PAGE_BYTES + NPAR + 1);
  localparam logic [CW-1:0] GEN_END = CW'(PAGE_BYTES);
  localparam logic [CW-1:0] CHK_END = CW'(PAGE_BYTES + NPAR);
  localparam logic [CW-1:0] CHK_LAST = CW'(PAGE_BYTES + NPAR - 1);

  logic [CW-1:0] cnt;
  logic full, last;

  assign full         = gen_mode ? (cnt >= GEN_END) : (cnt >= CHK_END);
  assign in_ready     = feed_en & ~full & ~ctrl_wr;
  assign step         = in_valid & in_ready;
  assign clr          = ctrl_wr & wr_clr;
  assign parity_phase = (cnt >= GEN_END);
  assign last         = step & ~gen_mode & (cnt == CHK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_mode <= 1'b0;
      feed_en  <= 1'b0;
      cnt      <= '0;
      err      <= 1'b0;
    end else if (ctrl_wr) begin
      gen_mode <= wr_gen;
      feed_en  <= wr_feed;
      if (wr_clr) begin
        cnt <= '0;
        err <= 1'b0;
      end
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (last) err <= rem_nz;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CHK_END);
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_en && !ctrl_wr) |=> ($stable(cnt) && $stable(err)));
  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(step));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !err));
endmodule

// File: rtl/rsp_regbank.sv
`timescale 1ns/1ps
module rsp_regbank
  import rsp_pkg::*;
(
  input  rem_t        rem,
  input  logic        gen_mode,
  input  logic        feed_en,
  input  logic        err,
  input  logic [4:0]  addr,
  output logic [15:0] rdata
);
  localparam int RAW_W  = NPAR * SYM_W;
  localparam int NBYTES = (RAW_W + 7) / 8;
  localparam int PAD    = NBYTES * 8 - RAW_W;
  localparam int SEL_W  = $clog2(NBYTES);

  logic [RAW_W-1:0]    raw;
  logic [NBYTES*8-1:0] pk, ipk;
  logic [7:0]          plain_b [NBYTES];
  logic [7:0]          inv_b   [NBYTES];

  // highest-order coefficient in the lowest field
  for (genvar k = 0; k < NPAR; k++) begin : g_pack
    assign raw[SYM_W*k +: SYM_W] = rem[NPAR-1-k];
  end

  assign pk  = {{PAD{1'b1}}, raw};
  assign ipk = {{PAD{1'b1}}, ~raw};

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign inv_b[b] = ipk[8*b +: 8];
    for (genvar t = 0; t < 8; t++) begin : g_bit
      assign plain_b[b][t] = pk[8*b + 7 - t];
    end
  end

  logic [7:0] sel;
  always_comb begin
    sel = 8'h00;
    if (addr == ADDR_CTRL)     sel = {1'b0, gen_mode, feed_en, 5'b0};
    else if (addr == ADDR_CHK) sel = {err, 7'b0};
    else if (addr[4:3] == 2'b01) sel = plain_b[addr[SEL_W-1:0]];
    else if (addr[4:3] == 2'b10) sel = inv_b[addr[SEL_W-1:0]];
  end
  assign rdata = {8'h00, sel};
endmodule

// File: rtl/nand_rs_parity.sv
`timescale 1ns/1ps
module nand_rs_parity
  import rsp_pkg::*;
#(
  parameter int PAGE_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [9:0]  in_data,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [15:0] reg_rdata
);
  logic ctrl_wr, step, clr, parity_phase, gen_mode, feed_en, err;
  sym_t sym;
  rem_t rem, rem_nxt;
  logic unused_wbits;

  assign ctrl_wr      = reg_we & (reg_addr == ADDR_CTRL);
  assign unused_wbits = ^reg_wdata[4:0];
  // every symbol is inverted; data bytes get zero upper bits
  assign sym = parity_phase ? ~in_data : {2'b00, ~in_data[7:0]};

  rsp_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk, .rst_n,
    .ctrl_wr,
    .wr_clr (reg_wdata[7]),
    .wr_gen (reg_wdata[6]),
    .wr_feed(reg_wdata[5]),
    .in_valid,
    .rem_nz (|rem_nxt),
    .in_ready, .step, .clr, .parity_phase, .gen_mode, .feed_en, .err
  );

  rsp_lfsr u_lfsr (
    .clk, .rst_n, .clr, .step, .sym, .rem, .rem_nxt
  );

  rsp_regbank u_regs (
    .rem, .gen_mode, .feed_en, .err, .addr(reg_addr), .rdata(reg_rdata)
  );
endmodule

// File: tb/nand_rs_parity_bench.sv
`timescale 1ns/1ps
module nand_rs_parity_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_data = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;

  always #2.5 clk = ~clk;

  nand_rs_parity u_nand_rs_parity (.*);

  int n_chk = 0, n_bad = 0, miss = 0;
  bit done = 1'b0;
  logic [15:0] last_rd;
  int gexp [0:1023];
  int glog [0:1023];
  int ghi  [0:6];
  int rem_e[0:5];
  int m    [0:517];

  // {mul, add, corrupt index (FFFF = none)}; byte i = (i*mul + add) & 255
  localparam logic [31:0] VEC [0:5] = '{
    {8'd0,  8'hFF, 16'hFFFF},
    {8'd0,  8'h00, 16'hFFFF},
    {8'd1,  8'h00, 16'hFFFF},
    {8'd37, 8'd11, 16'd100},
    {8'd5,  8'd200, 16'd514},
    {8'd3,  8'd7,  16'd511}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 1023];
  endfunction

  task automatic build_field();
    int e = 1;
    int p[0:6];
    int root = 1;
    for (int i = 0; i < 1023; i++) begin
      gexp[i] = e; glog[e] = i;
      e = e << 1;
      if (e & 1024) e = e ^ 'h409;
    end
    for (int k = 0; k < 7; k++) p[k] = 0;
    p[0] = 1;
    for (int r = 0; r < 6; r++) begin
      for (int k = 6; k >= 1; k--) p[k] = p[k-1] ^ bmul(p[k], root);
      p[0] = bmul(p[0], root);
      root = bmul(root, 2);
    end
    for (int j = 0; j < 7; j++) ghi[j] = p[6-j];
  endtask

  function automatic int byte_at(int i, int mul, int add);
    return (i * mul + add) & 255;
  endfunction

  task automatic compute_rem(input int mul, input int add);
    for (int i = 0; i < 518; i++) m[i] = (i < 512) ? ((~byte_at(i, mul, add)) & 255) : 0;
    for (int i = 0; i < 512; i++) begin
      int c = m[i];
      if (c != 0) for (int j = 1; j < 7; j++) m[i+j] = m[i+j] ^ bmul(c, ghi[j]);
    end
    for (int k = 0; k < 6; k++) rem_e[k] = m[517-k];
  endtask

  function automatic logic [63:0] exp_word(input bit inverted);
    logic [63:0] w;
    w = 64'hF000_0000_0000_0000;
    for (int k = 0; k < 6; k++) begin
      logic [9:0] s = 10'(rem_e[5-k]);
      w[10*k +: 10] = inverted ? ~s : s;
    end
    return w;
  endfunction

  function automatic logic [63:0] mirror_bytes(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++)
      for (int t = 0; t < 8; t++) r[8*b + t] = w[8*b + 7 - t];
    return r;
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [9:0] s);
    @(negedge clk); in_valid = 1'b1; in_data = s;
    #1; if (!in_ready) miss++;
    last_rd = reg_rdata;
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0; #1;
  endtask

  task automatic read_banks(output logic [63:0] pl, output logic [63:0] iv);
    logic [15:0] d;
    for (int b = 0; b < 8; b++) begin
      rd(5'(8 + b), d);  pl[8*b +: 8] = d[7:0];
      rd(5'(16 + b), d); iv[8*b +: 8] = d[7:0];
    end
  endtask

  task automatic gen_run(input int mul, input int add);
    wr_ctrl(8'hE0);
    miss = 0;
    for (int i = 0; i < 512; i++) push(10'(byte_at(i, mul, add)));
    idle();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] d;
    logic [63:0] pl, iv, pl2, iv2;
    build_field();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'd0, d);  chk("R1 ctrl", 64'(d), 64'h0);
    rd(5'd1, d);  chk("R1 check", 64'(d), 64'h0);
    chk("R1 in_ready", 64'(in_ready), 64'h0);
    read_banks(pl, iv);
    chk("R1 inv bank", iv, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 plain bank", pl, 64'h0F00_0000_0000_0000);

    // vector walk
    for (int v = 0; v < 6; v++) begin
      int mul = int'(VEC[v][31:24]);
      int add = int'(VEC[v][23:16]);
      int bad = int'(VEC[v][15:0]);
      int mainmiss;
      compute_rem(mul, add);
      gen_run(mul, add);
      mainmiss = miss;
      chk("R2 ready during page", 64'(mainmiss), 64'h0);
      chk("R2 ready low when page full", 64'(in_ready), 64'h0);
      push(10'h155); idle();                 // ignored extra symbol (R2)
      read_banks(pl, iv);
      chk("R3 R5 inverted code", iv, exp_word(1'b1));
      chk("R6 plain code", pl, mirror_bytes(exp_word(1'b0)));
      if (v == 0) chk("R4 blank page code", iv, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(5'd1, d); chk("R7 flag idle in generate", 64'(d), 64'h0);

      // check run
      wr_ctrl(8'hA0);
      reg_addr = 5'd1;
      miss = 0;
      for (int i = 0; i < 512; i++) begin
        int bv = byte_at(i, mul, add);
        if (i == bad) bv = bv ^ 1;
        push(10'(bv));
      end
      for (int i = 0; i < 6; i++) begin
        logic [9:0] s = ~10'(rem_e[5-i]);
        if (512 + i == bad) s = s ^ 10'h001;
        push(s);
      end
      chk("R7 flag before last symbol", 64'(last_rd), 64'h0);
      chk("R2 check page accepted", 64'(miss), 64'h0);
      idle();
      chk("R7 flag after last symbol", 64'(reg_rdata), (bad != 16'hFFFF) ? 64'h80 : 64'h0);
      chk("R2 ready low after 518", 64'(in_ready), 64'h0);
    end

    // R8: clear drops a raised flag (last vector left it set)
    wr_ctrl(8'hA0);
    rd(5'd1, d); chk("R8 clear drops flag", 64'(d), 64'h0);

    // R9: stop holds state
    compute_rem(1, 0);
    gen_run(1, 0);
    wr_ctrl(8'h00);
    rd(5'd0, d); chk("R9 ctrl after stop", 64'(d), 64'h0);
    read_banks(pl, iv);
    miss = 0;
    for (int i = 0; i < 5; i++) push(10'(i * 41));
    idle();
    chk("R9 stream refused", 64'(miss), 64'h5);
    read_banks(pl2, iv2);
    chk("R9 inverted held", iv2, iv);
    chk("R9 plain held", pl2, pl);
    chk("R9 held value", iv2, exp_word(1'b1));

    // R8: clear with mode bits in one write
    wr_ctrl(8'hC0);
    rd(5'd0, d); chk("R8 mode load, clear reads 0", 64'(d), 64'h40);
    read_banks(pl, iv);
    chk("R8 state cleared", iv, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 feed off", 64'(in_ready), 64'h0);

    // R10 unmapped words
    rd(5'd2, d);  chk("R10 word 2", 64'(d), 64'h0);
    rd(5'd7, d);  chk("R10 word 7", 64'(d), 64'h0);
    rd(5'd24, d); chk("R10 word 24", 64'(d), 64'h0);
    rd(5'd31, d); chk("R10 word 31", 64'(d), 64'h0);

    done = 1'b1;
    report();
  end
endmodule